// File: doc/BRIEF.md
# Serial Two-Wire Byte Memory Slave

This block is the slave side of a two-wire serial memory. It oversamples the bus clock (SCL) and data (SDA) lines with the system clock and finds START and STOP conditions in that domain. After each START it takes a select byte. The select byte is compared against a fixed device-type code and three strap pins, so up to eight such slaves can share one bus. Next comes a one-byte word address. After that the master either writes bytes into a small staging buffer or reads bytes back from a register-array memory, with the pointer advancing automatically.

The block only ever pulls SDA low, through an output-enable. The board or the bench supplies the pull-up. When a STOP closes a write that carried at least one data byte, the block enters a timed programming phase and holds a busy flag. During that phase it ignores the bus completely. At the end of the phase the staged bytes are copied into the memory in a single clock. A random read is a write of the address alone, then a repeated START, then a read select byte.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset `sda_oe_o` and `busy_o` are 0 and every memory byte reads back as 0x00.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked without a preceding START get no acknowledge.
- R3: The select byte is sent MSB first. Bits 7:4 must equal the type code (default 4'b1010), bits 3:1 must equal `ce_i`, and bit 0 is the direction (1 = read, 0 = write). On a mismatch the block gives no acknowledge and ignores the bus until the next START.
- R4: The block acknowledges by holding SDA low for the whole 9th clock after a matching select byte, after an address byte, and after each accepted write byte. At all other times it leaves SDA released, except when it is sending read data.
- R5: The block takes in SDA on SCL rising edges. It changes its own SDA drive only while SCL is low.
- R6: The low log2(MEM_DEPTH) bits of the address byte set the pointer, so addresses wrap modulo MEM_DEPTH (default 32). Up to BUF_DEPTH (default 4) write bytes are staged and acknowledged. Further bytes are neither acknowledged nor stored. Write data does not move the pointer.
- R7: A STOP after a write with at least one staged byte raises `busy_o` for PROG_CYCLES (default 400) clocks. When it ends, staged byte i lands at (address + i) mod MEM_DEPTH. A STOP after an address-only write leaves `busy_o` low.
- R8: While `busy_o` is high, START and every other bus event are ignored and SDA is never pulled low.
- R9: A read returns memory[pointer] MSB first, and the pointer advances by one (wrapping) after every byte sent. A master acknowledge causes the next byte to be sent. A master not-acknowledge makes the block release SDA and stay silent until STOP or START.
- R10: A START in the middle of a transaction (repeated START) restarts select-byte reception without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| ce_i | input | 3 | Strap value matched against select bits 3:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | High while the programming phase runs |

## Verification
A wrong bit counter or a wrong state shows up at the 9th clock of the next byte: either an acknowledge is missing, or an unexpected low appears on the wire. A wrong pointer or a wrong staging slot only shows when the data is read back after the programming phase, so every write is followed by a read that is compared against a model memory. Errors in the busy length or the commit appear on `busy_o` within PROG_CYCLES clocks of the STOP, and in the first read that follows.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT,
    ST_PROG
  } ee_state_e;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // both SCL samples high: SDA moved during the high phase
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES);
  logic [CNT_W-1:0] cnt_q;
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(CYCLES-1)) busy_q <= 1'b0;
      else cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(CYCLES-1));

  AST_PROG_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == CNT_W'(CYCLES-1)); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int DEPTH     = 32,
  parameter int BUF_DEPTH = 4,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(BUF_DEPTH+1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      commit_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [BUF_DEPTH-1:0][7:0] buf_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [7:0]                rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic       we;
    logic [7:0] wd;
    always_comb begin
      logic [ADDR_W-1:0] tgt;
      we = 1'b0;
      wd = '0;
      for (int i = 0; i < BUF_DEPTH; i++) begin
        tgt = base_i + ADDR_W'(i);
        if (CNT_W'(i) < cnt_i && tgt == ADDR_W'(j)) begin
          we = commit_i;
          wd = buf_i[i];
        end
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[j] <= '0;
      else if (we) mem_q[j] <= wd;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_i2c_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         MEM_DEPTH   = 32,
  parameter int         BUF_DEPTH   = 4,
  parameter int         PROG_CYCLES = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int ADDR_W = $clog2(MEM_DEPTH);
  localparam int CNT_W  = $clog2(BUF_DEPTH+1);
  localparam int BUF_W  = $clog2(BUF_DEPTH);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic prog_start, prog_done;
  logic [7:0] rd_data;
  logic [ADDR_W-1:0] rd_addr;

  ee_state_e state_q;
  logic [3:0] bit_cnt_q;
  logic in_ack_q, sda_oe_q, rw_q, mack_q;
  logic [7:0] rx_q, tx_q;
  logic [ADDR_W-1:0] ptr_q, base_q;
  logic [CNT_W-1:0] wr_cnt_q;
  logic [BUF_DEPTH-1:0][7:0] buf_q;

  ee_bus_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy_o), .done_o(prog_done)
  );

  ee_mem_array #(.DEPTH(MEM_DEPTH), .BUF_DEPTH(BUF_DEPTH)) u_mem (
    .clk_i, .rst_ni, .commit_i(prog_done), .base_i(base_q), .cnt_i(wr_cnt_q),
    .buf_i(buf_q), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  assign prog_start = stop_det && state_q == ST_WDATA && wr_cnt_q != '0;
  // during a read the next byte is fetched one ahead of the pointer
  assign rd_addr    = (state_q == ST_RDATA) ? ptr_q + ADDR_W'(1) : ptr_q;
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      base_q    <= '0;
      wr_cnt_q  <= '0;
      buf_q     <= '0;
    end else if (start_det && state_q != ST_PROG) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (stop_det && state_q != ST_PROG) begin
      state_q  <= prog_start ? ST_PROG : ST_IDLE;
      in_ack_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_WAIT: ;
        ST_PROG: if (prog_done) state_q <= ST_IDLE;
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && !in_ack_q && bit_cnt_q != 4'd8) begin
            rx_q      <= {rx_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && !in_ack_q && bit_cnt_q == 4'd8) begin
            in_ack_q <= 1'b1;
            if (state_q == ST_DEV) begin
              rw_q <= rx_q[0];
              if (rx_q[7:4] == TYPE_CODE && rx_q[3:1] == ce_i) sda_oe_q <= 1'b1;
              else begin
                state_q   <= ST_IDLE;
                in_ack_q  <= 1'b0;
                bit_cnt_q <= '0;
              end
            end else if (state_q == ST_ADDR) begin
              sda_oe_q <= 1'b1;
              base_q   <= rx_q[ADDR_W-1:0];
              ptr_q    <= rx_q[ADDR_W-1:0];
              wr_cnt_q <= '0;
            end else if (wr_cnt_q < CNT_W'(BUF_DEPTH)) begin
              sda_oe_q <= 1'b1;
              buf_q[wr_cnt_q[BUF_W-1:0]] <= rx_q;
              wr_cnt_q <= wr_cnt_q + CNT_W'(1);
            end
          end else if (scl_fall && in_ack_q) begin
            in_ack_q  <= 1'b0;
            bit_cnt_q <= '0;
            sda_oe_q  <= 1'b0;
            if (state_q == ST_DEV) begin
              if (rw_q) begin
                state_q  <= ST_RDATA;
                tx_q     <= rd_data;
                sda_oe_q <= ~rd_data[7];
              end else state_q <= ST_ADDR;
            end else if (state_q == ST_ADDR) state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (!in_ack_q) begin
            if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
            else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                in_ack_q <= 1'b1;
              end else begin
                tx_q     <= {tx_q[6:0], 1'b0};
                sda_oe_q <= ~tx_q[6];
              end
            end
          end else if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            in_ack_q <= 1'b0;
            ptr_q    <= ptr_q + ADDR_W'(1);
            if (mack_q) begin
              tx_q      <= rd_data;
              sda_oe_q  <= ~rd_data[7];
              bit_cnt_q <= '0;
            end else state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !$past(scl_s)); // R5
  AST_RX_ACK_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q && state_q != ST_RDATA) |-> in_ack_q); // R4
  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_q); // R8
  AST_BUF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= CNT_W'(BUF_DEPTH)); // R6
  AST_WAIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT |-> !sda_oe_q); // R9
endmodule

// File: tb/ee_i2c_slave_bench.sv
`timescale 1ns/1ps
module ee_i2c_slave_bench;
  localparam int DEPTH = 32;
  localparam int BUFD  = 4;
  localparam int PROG  = 400;
  localparam int Q     = 5;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy;
  logic sda_line;
  int   vectors = 0, errors = 0;
  int   cyc = 0;
  logic [7:0] model [DEPTH];
  int   mptr = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign sda_line = sda_m & ~sda_oe;

  ee_i2c_slave u_ee_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .ce_i(CE),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  function automatic logic [7:0] sel(input bit rd);
    return {4'b1010, CE, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic bstop();  sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask
  task automatic wbit(input bit b); sda_m = b; wq(); scl = 1; wq(); wq(); scl = 0; wq(); endtask
  task automatic rbit(output bit b); sda_m = 1; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq(); endtask

  task automatic send(input logic [7:0] d, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic recv(input bit mack, output logic [7:0] d);
    bit x;
    for (int i = 7; i >= 0; i--) begin rbit(x); d[i] = x; end
    wbit(!mack);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // write transaction: n data bytes (n may be 0), model updated after commit
  task automatic wr_txn(input int addr, input int n);
    bit ack;
    logic [7:0] d;
    logic [7:0] stg [BUFD];
    int acc = 0;
    bstart();
    send(sel(0), ack); chk(ack, "R4 select ack", ack, 1);
    send(8'(addr), ack); chk(ack, "R4 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send(d, ack);
      chk(ack == (k < BUFD), "R6 write byte ack", ack, (k < BUFD));
      if (k < BUFD) begin stg[k] = d; acc++; end
    end
    bstop();
    mptr = addr % DEPTH;
    if (acc > 0) begin
      wait_idle();
      for (int k = 0; k < acc; k++) model[(addr + k) % DEPTH] = stg[k];
    end
  endtask

  // read transaction: addr < 0 reads from the current pointer
  task automatic rd_txn(input int addr, input int n);
    bit ack;
    logic [7:0] d;
    bstart();
    if (addr >= 0) begin
      send(sel(0), ack); chk(ack, "R10 select ack", ack, 1);
      send(8'(addr), ack); chk(ack, "R10 address ack", ack, 1);
      mptr = addr % DEPTH;
      bstart();
    end
    send(sel(1), ack); chk(ack, "R3 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(k < n - 1, d);
      chk(d == model[mptr], "R9 read data", d, model[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    bstop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    int t0;
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !busy, "R1 reset outputs", {sda_oe, busy}, 0);

    // R2: no START, no ack
    send(sel(0), ack); chk(!ack, "R2 no start", ack, 0);
    bstop();
    // R3: wrong type code, wrong strap, then silence
    bstart(); send(8'hB0 | {4'h0, CE, 1'b0}, ack); chk(!ack, "R3 type mismatch", ack, 0); bstop();
    bstart(); send({4'b1010, ~CE, 1'b0}, ack); chk(!ack, "R3 strap mismatch", ack, 0);
    send(8'h00, ack); chk(!ack, "R3 ignored after mismatch", ack, 0); bstop();

    // R1 + R10: random read of reset content
    rd_txn(0, 2);

    // R7 wrap and timing, R8 busy lockout
    bstart(); send(sel(0), ack); send(8'hFF, ack);
    send(8'h11, ack); send(8'h22, ack); send(8'h33, ack);
    bstop();
    t0 = cyc;
    chk(busy, "R7 busy after stop", busy, 1);
    bstart(); send(sel(0), ack); chk(!ack, "R8 start ignored while busy", ack, 0); bstop();
    while (cyc < t0 + PROG - 20) @(negedge clk);
    chk(busy, "R7 busy before end", busy, 1);
    while (cyc < t0 + PROG + 10) @(negedge clk);
    chk(!busy, "R7 busy cleared", busy, 0);
    model[31] = 8'h11; model[0] = 8'h22; model[1] = 8'h33;
    rd_txn(31, 3);

    // R6 overflow
    wr_txn(8, 6);
    rd_txn(8, 6);

    // R7 address-only write: no busy; R6 pointer from address
    wr_txn(37, 0);
    repeat (10) @(negedge clk);
    chk(!busy, "R7 no busy without data", busy, 0);
    rd_txn(-1, 2);

    // R9 silence after master nack
    rd_txn(3, 1);
    bstart(); send(sel(1), ack); recv(0, d);
    recv(0, d); chk(d == 8'hFF, "R9 silent after nack", d, 8'hFF);
    bstop();
    mptr = 5;

    // constrained random mix
    for (int it = 0; it < 20; it++) begin
      wr_txn(int'($urandom % 256), 1 + int'($urandom % (BUFD + 2)));
      if ($urandom % 2) rd_txn(-1, 1 + int'($urandom % 6));
      else rd_txn(int'($urandom % 256), 1 + int'($urandom % 6));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule